// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a serial audio stream into parallel samples. It takes three external lines: bit clock, frame clock and data. It returns a 24-bit sample together with a channel index, marked by a strobe that is high for one cycle. The receiver is always a clock slave. It oversamples the three lines with a faster system clock, so the system clock must run at least four times the bit clock. All decisions are made on bit-clock events detected in the system clock domain.

A static configuration selects the framing. The supported framings are a one-bit-delayed stereo format, a left-justified stereo format, four right-justified widths, and an 8-slot time-division format. Two further bits select the frame-clock level that means "left / slot 0" and the bit-clock edge on which data is taken. In every framing except right-justified, the number of bit clocks per word or frame is free. Words longer than 24 bits are cut to 24. A word cut short by the next frame-clock transition is delivered left-aligned with zero low bits. A frame-clock transition in mid-word restarts the bit count, so the receiver falls back into step after a glitch.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held low, and until the first sample is produced, `smp_valid`, `smp_chan` and `smp_data` are all zero.
- R2: Format code 0 (delayed stereo) takes the sample MSB on the second bit event after a frame-clock transition and collects 24 bits MSB first. Channel 0 is the word that starts at the transition into the active level, and channel 1 is the word that starts at the transition out of it.
- R3: Format code 1 (left-justified) takes the MSB on the first bit event after the transition and otherwise behaves like R2. Code 7 behaves exactly like code 1.
- R4: Codes 2, 3, 4 and 5 are right-justified with widths 24, 20, 18 and 16. Their MSB comes on bit event 8, 12, 14 and 16 after the transition (counting the transition bit as 0). The sample ends on bit 31 and is left-aligned in `smp_data`, with the unused low bits zero.
- R5: Code 6 is time-division. A frame starts at the transition into the active level. Slot k occupies bit events 32k to 32k+31, and slot k's 24-bit sample is taken from the first 24 of those bits, MSB first, with `smp_chan` = k. Bits 24 to 31 of each slot, and any bit after bit 255 of a frame, change no output.
- R6: With `cfg_fs_pol` = 0 the active (left/slot 0) level of the frame clock is low. With `cfg_fs_pol` = 1 it is high.
- R7: With `cfg_bclk_fall` = 0 data and frame clock are taken on bit-clock rising edges. With 1 they are taken on falling edges.
- R8: In codes 0, 1 and 7, a word of more than 24 data bits yields its first 24 bits, and the extra bits change no output. A word ended early by a frame-clock transition is delivered at that transition, holding the bits received, left-aligned, with zeros below.
- R9: Each sample is a `smp_valid` pulse exactly one system cycle wide. In stereo formats `smp_chan` is 0 or 1.
- R10: No sample is produced before the first frame-clock transition after reset. A frame-clock transition in the middle of a word restarts the bit count, so complete frames received after a glitch are delivered correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 3 | Framing code (see R2 to R5) |
| cfg_fs_pol | input | 1 | Frame-clock level meaning left / slot 0 |
| cfg_bclk_fall | input | 1 | 1 = take data on falling bit-clock edge |
| ser_bclk | input | 1 | External bit clock |
| ser_fsync | input | 1 | External frame clock |
| ser_data | input | 1 | External serial data |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_chan | output | 3 | Channel or slot index of the sample |
| smp_data | output | 24 | Recovered sample, MSB aligned |

## Verification
A wrong bit position appears in the very next sample as a shifted or bit-swapped value. A wrong channel register or channel flip appears as a channel index that does not match the order in which the samples were sent. A fault in the word-start logic, such as a missed transition or a bad polarity, either drops a short word or delivers samples in the wrong slot within one frame. A stuck pending flag shows up as an extra or missing strobe by the next frame-clock transition. Every sample is compared in order against arithmetically generated values, so any such fault is reported at the first affected sample.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

  typedef enum logic [2:0] {
    FMT_DLY   = 3'd0,
    FMT_LJ    = 3'd1,
    FMT_RJ24  = 3'd2,
    FMT_RJ20  = 3'd3,
    FMT_RJ18  = 3'd4,
    FMT_RJ16  = 3'd5,
    FMT_TDM   = 3'd6,
    FMT_ALTLJ = 3'd7
  } fmt_e;

  // Bit index (within a word) of the sample MSB
  function automatic logic [5:0] fmt_lead(input logic [2:0] f);
    case (f)
      FMT_DLY:  fmt_lead = 6'd1;
      FMT_RJ24: fmt_lead = 6'd8;
      FMT_RJ20: fmt_lead = 6'd12;
      FMT_RJ18: fmt_lead = 6'd14;
      FMT_RJ16: fmt_lead = 6'd16;
      default:  fmt_lead = 6'd0;
    endcase
  endfunction

  // Number of meaningful data bits per word
  function automatic logic [5:0] fmt_width(input logic [2:0] f);
    case (f)
      FMT_RJ20: fmt_width = 6'd20;
      FMT_RJ18: fmt_width = 6'd18;
      FMT_RJ16: fmt_width = 6'd16;
      default:  fmt_width = 6'd24;
    endcase
  endfunction

  function automatic logic fmt_is_tdm(input logic [2:0] f);
    return f == FMT_TDM;
  endfunction

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d_in;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/sarx_edge.sv
module sarx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_fall,
  input  logic bclk_s,
  output logic bit_evt
);
  logic bclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= bclk_s;
  end

  assign bit_evt = bclk_fall ? (bclk_d & ~bclk_s) : (~bclk_d & bclk_s);
endmodule

// File: rtl/sarx_framer.sv
module sarx_framer
  import sarx_pkg::*;
#(
  parameter int SMP_W    = 24,
  parameter int SLOTS    = 8,
  parameter int SLOT_LEN = 32,
  localparam int CH_W       = $clog2(SLOTS),
  localparam int SLOT_W     = $clog2(SLOT_LEN),
  localparam int FRAME_BITS = SLOTS * SLOT_LEN,
  localparam int POS_W      = $clog2(FRAME_BITS) + 1,
  localparam int REL_W      = $clog2(SMP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       fmt,
  input  logic             fs_pol,
  input  logic             bit_evt,
  input  logic             fs_bit,
  output logic             word_start,
  output logic             slot_start,
  output logic             capture,
  output logic             full_done,
  output logic [REL_W-1:0] rel,
  output logic [CH_W-1:0]  cur_chan,
  output logic             locked
);
  logic [POS_W-1:0] pos_q, pos_nxt, lead_w, width_w, rel_full;
  logic             fs_last, primed, chan_bit_q, locked_q;
  logic             tdm, fs_edge, fs_active, lock_now, in_frame;
  logic [SLOT_W-1:0] bis;
  logic [CH_W-1:0]   slot;

  assign tdm        = fmt_is_tdm(fmt);
  assign fs_active  = (fs_bit == fs_pol);
  assign fs_edge    = primed && (fs_bit != fs_last);
  assign word_start = bit_evt && fs_edge && (!tdm || fs_active);
  assign lock_now   = locked_q || word_start;

  always_comb begin
    if (word_start)  pos_nxt = '0;
    else if (&pos_q) pos_nxt = pos_q;
    else             pos_nxt = pos_q + 1'b1;
  end

  assign lead_w   = POS_W'(fmt_lead(fmt));
  assign width_w  = tdm ? POS_W'(SMP_W) : POS_W'(fmt_width(fmt));
  assign bis      = pos_nxt[SLOT_W-1:0];
  assign slot     = pos_nxt[SLOT_W +: CH_W];
  assign in_frame = pos_nxt < POS_W'(FRAME_BITS);
  assign rel_full = tdm ? POS_W'(bis) : (pos_nxt - lead_w);

  always_comb begin
    if (tdm)
      capture = bit_evt && lock_now && in_frame && (POS_W'(bis) < width_w);
    else
      capture = bit_evt && lock_now && (pos_nxt >= lead_w) &&
                (pos_nxt < lead_w + width_w);
  end

  assign slot_start = tdm && bit_evt && lock_now && in_frame && (bis == '0);
  assign full_done  = capture && (rel_full == width_w - 1'b1);
  assign rel        = rel_full[REL_W-1:0];

  always_comb begin
    if (tdm)             cur_chan = slot;
    else if (word_start) cur_chan = fs_active ? '0 : CH_W'(1);
    else                 cur_chan = CH_W'(chan_bit_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q      <= '0;
      fs_last    <= 1'b0;
      primed     <= 1'b0;
      chan_bit_q <= 1'b0;
      locked_q   <= 1'b0;
    end else if (bit_evt) begin
      pos_q    <= pos_nxt;
      fs_last  <= fs_bit;
      primed   <= 1'b1;
      locked_q <= lock_now;
      if (word_start) chan_bit_q <= !fs_active;
    end
  end

  assign locked = locked_q;
endmodule

// File: rtl/sarx_assemble.sv
module sarx_assemble #(
  parameter int SMP_W = 24,
  parameter int CH_W  = 3,
  parameter int REL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_start,
  input  logic             slot_start,
  input  logic             capture,
  input  logic             full_done,
  input  logic [REL_W-1:0] rel,
  input  logic             dat_bit,
  input  logic [CH_W-1:0]  cur_chan,
  output logic             smp_valid,
  output logic [CH_W-1:0]  smp_chan,
  output logic [SMP_W-1:0] smp_data
);
  logic [SMP_W-1:0] acc_q, acc_base, acc_nxt, put_mask;
  logic [CH_W-1:0]  wchan_q;
  logic             pend_q, clear, short_emit;

  assign clear      = word_start || slot_start;
  assign short_emit = word_start && pend_q;
  assign put_mask   = {1'b1, {(SMP_W-1){1'b0}}} >> rel;
  assign acc_base   = clear ? '0 : acc_q;
  assign acc_nxt    = capture ? ((acc_base & ~put_mask) | ({SMP_W{dat_bit}} & put_mask))
                              : acc_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      wchan_q   <= '0;
      pend_q    <= 1'b0;
      smp_valid <= 1'b0;
      smp_chan  <= '0;
      smp_data  <= '0;
    end else begin
      if (clear || capture) acc_q <= acc_nxt;
      if (capture)          wchan_q <= cur_chan;

      if (full_done)      pend_q <= 1'b0;
      else if (capture)   pend_q <= 1'b1;
      else if (short_emit) pend_q <= 1'b0;

      if (full_done) begin
        smp_valid <= 1'b1;
        smp_data  <= acc_nxt;
        smp_chan  <= cur_chan;
      end else if (short_emit) begin
        smp_valid <= 1'b1;
        smp_data  <= acc_q;
        smp_chan  <= wchan_q;
      end else begin
        smp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int SMP_W       = 24,
  parameter int SLOTS       = 8,
  parameter int SLOT_LEN    = 32,
  localparam int CH_W  = $clog2(SLOTS),
  localparam int REL_W = $clog2(SMP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_fmt,
  input  logic             cfg_fs_pol,
  input  logic             cfg_bclk_fall,
  input  logic             ser_bclk,
  input  logic             ser_fsync,
  input  logic             ser_data,
  output logic             smp_valid,
  output logic [CH_W-1:0]  smp_chan,
  output logic [SMP_W-1:0] smp_data
);
  logic [2:0] raw_in, sync_out;
  logic       bclk_s, fs_bit, dat_bit, bit_evt;
  logic       word_start, slot_start, capture, full_done, locked;
  logic [REL_W-1:0] rel;
  logic [CH_W-1:0]  cur_chan;

  assign raw_in = {ser_data, ser_fsync, ser_bclk};

  sarx_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(raw_in), .d_out(sync_out)
  );

  assign bclk_s  = sync_out[0];
  assign fs_bit  = sync_out[1];
  assign dat_bit = sync_out[2];

  sarx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .bclk_fall(cfg_bclk_fall),
    .bclk_s(bclk_s), .bit_evt(bit_evt)
  );

  sarx_framer #(.SMP_W(SMP_W), .SLOTS(SLOTS), .SLOT_LEN(SLOT_LEN)) u_framer (
    .clk(clk), .rst_n(rst_n), .fmt(cfg_fmt), .fs_pol(cfg_fs_pol),
    .bit_evt(bit_evt), .fs_bit(fs_bit), .word_start(word_start),
    .slot_start(slot_start), .capture(capture), .full_done(full_done),
    .rel(rel), .cur_chan(cur_chan), .locked(locked)
  );

  sarx_assemble #(.SMP_W(SMP_W), .CH_W(CH_W), .REL_W(REL_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .word_start(word_start), .slot_start(slot_start),
    .capture(capture), .full_done(full_done), .rel(rel), .dat_bit(dat_bit),
    .cur_chan(cur_chan), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data)
  );
endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
  parameter int CH_W  = 3,
  parameter int SMP_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       fmt,
  input logic             smp_valid,
  input logic [CH_W-1:0]  smp_chan,
  input logic [SMP_W-1:0] smp_data,
  input logic             bit_evt,
  input logic             locked
);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);

  a_r9_stereo_chan: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fmt != 3'd6) |-> (smp_chan <= CH_W'(1)));

  a_r4_rj16_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fmt == 3'd5 && $stable(fmt)) |-> (smp_data[SMP_W-17:0] == '0));

  a_r4_rj18_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fmt == 3'd4 && $stable(fmt)) |-> (smp_data[SMP_W-19:0] == '0));

  a_r4_rj20_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fmt == 3'd3 && $stable(fmt)) |-> (smp_data[SMP_W-21:0] == '0));

  a_r10_valid_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(bit_evt));

  a_r10_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !smp_valid);
endmodule

bind serial_audio_rx serial_audio_rx_chk #(.CH_W(CH_W), .SMP_W(SMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmt(cfg_fmt), .smp_valid(smp_valid),
  .smp_chan(smp_chan), .smp_data(smp_data), .bit_evt(bit_evt), .locked(locked)
);

// File: tb/serial_audio_rx_tb_top.sv
module serial_audio_rx_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic        pol = 1'b0, bfall = 1'b0, bclk_raw = 1'b0, fsync = 1'b0, sdata = 1'b0;
  logic        smp_valid;
  logic [2:0]  smp_chan;
  logic [23:0] smp_data;
  wire         bclk_line = bclk_raw ^ bfall;

  serial_audio_rx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(fmt), .cfg_fs_pol(pol),
    .cfg_bclk_fall(bfall), .ser_bclk(bclk_line), .ser_fsync(fsync),
    .ser_data(sdata), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data)
  );

  int checks = 0, errors = 0, wr = 0, rd = 0, vcount = 0;
  bit ignore = 1'b0, prev_v = 1'b0;
  string req = "R1";
  logic [23:0] exp_d [0:1023];
  logic [2:0]  exp_c [0:1023];

  task automatic chk(input bit ok, input string r, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic int b_lead(input logic [2:0] f);
    case (f)
      3'd0: return 1;  3'd2: return 8;  3'd3: return 12;
      3'd4: return 14; 3'd5: return 16; default: return 0;
    endcase
  endfunction

  function automatic int b_width(input logic [2:0] f);
    case (f)
      3'd3: return 20; 3'd4: return 18; 3'd5: return 16; default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] topbits(input logic [23:0] v, input int n);
    if (n >= 24) return v;
    if (n <= 0)  return 24'd0;
    return v & ~((24'(1) << (24 - n)) - 24'(1));
  endfunction

  function automatic logic [23:0] mk(input int seed, input int k, input int w);
    logic [23:0] v;
    v = 24'(seed * 40503 + k * 9973 + 370085);
    return topbits(v, w);
  endfunction

  function automatic logic filler(input int i);
    return ((i * 13 + 5) & 4) != 0;
  endfunction

  // Sample monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n && smp_valid) begin
      vcount++;
      chk(!prev_v, "R9", "strobe wider than one cycle", 1, 0);
      if (!ignore) begin
        if (rd >= wr) chk(1'b0, req, "unexpected sample", int'(smp_data), 0);
        else begin
          chk(smp_data == exp_d[rd] && smp_chan == exp_c[rd], req, "sample {chan,data}",
              int'({smp_chan, smp_data}), int'({exp_c[rd], exp_d[rd]}));
          rd++;
        end
      end
    end
    prev_v = rst_n && smp_valid;
  end

  task automatic push(input logic [2:0] c, input logic [23:0] d);
    exp_c[wr] = c; exp_d[wr] = d; wr++;
  endtask

  task automatic send_bit(input logic f, input logic d);
    fsync = f; sdata = d;
    repeat (4) @(negedge clk);
    bclk_raw = 1'b1;
    repeat (4) @(negedge clk);
    bclk_raw = 1'b0;
  endtask

  task automatic start_run(input logic [2:0] f, input logic p, input logic bf, input string r);
    int base;
    req = r; rst_n = 1'b0; fmt = f; pol = p; bfall = bf;
    bclk_raw = 1'b0; fsync = ~p; sdata = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    base = vcount;
    for (int i = 0; i < 4; i++) send_bit(~p, filler(i));
    repeat (4) @(negedge clk);
    chk(vcount == base, "R10", "strobe before first transition", vcount - base, 0);
  endtask

  task automatic end_run();
    send_bit(pol, 1'b0);
    repeat (20) @(negedge clk);
    chk(rd == wr, req, "samples delivered", rd, wr);
    rd = wr;
  endtask

  task automatic stereo_frame(input int hl, input int seed);
    int lead, w, n, rel;
    logic [23:0] s;
    logic b;
    lead = b_lead(fmt); w = b_width(fmt);
    for (int ch = 0; ch < 2; ch++) begin
      s = mk(seed, ch, w);
      n = hl - lead;
      if (n > w) n = w;
      if (n > 0) push(3'(ch), topbits(s, n));
      for (int i = 0; i < hl; i++) begin
        rel = i - lead;
        if (rel >= 0 && rel < w) b = s[23 - rel];
        else b = filler(i + ch);
        send_bit(ch == 0 ? pol : ~pol, b);
      end
    end
  endtask

  task automatic tdm_frame(input int nbits, input int seed);
    logic [23:0] v [0:7];
    int slot, bi;
    logic b;
    for (int k = 0; k < 8; k++) begin
      v[k] = mk(seed, k, 24);
      push(3'(k), v[k]);
    end
    for (int i = 0; i < nbits; i++) begin
      slot = i / 32; bi = i % 32;
      if (i < 256 && bi < 24) b = v[slot][23 - bi];
      else b = filler(i);
      send_bit(i == 0 ? pol : ~pol, b);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (5) @(negedge clk);
    chk(smp_valid == 1'b0 && smp_chan == 3'd0 && smp_data == 24'd0, "R1",
        "outputs in reset", int'({smp_valid, smp_chan, smp_data}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(smp_valid == 1'b0 && smp_data == 24'd0, "R1", "outputs after reset",
        int'({smp_valid, smp_data}), 0);

    // R2: delayed stereo, active low
    start_run(3'd0, 1'b0, 1'b0, "R2");
    for (int f = 0; f < 3; f++) stereo_frame(32, 11 + f);
    end_run();
    // R6: active high polarity
    start_run(3'd0, 1'b1, 1'b0, "R6");
    for (int f = 0; f < 2; f++) stereo_frame(32, 21 + f);
    end_run();
    // R7: falling-edge sampling, left-justified
    start_run(3'd1, 1'b0, 1'b1, "R7");
    for (int f = 0; f < 2; f++) stereo_frame(24, 31 + f);
    end_run();
    // R3: left-justified and code 7
    start_run(3'd1, 1'b1, 1'b0, "R3");
    stereo_frame(30, 41); stereo_frame(30, 42);
    end_run();
    start_run(3'd7, 1'b0, 1'b0, "R3");
    stereo_frame(28, 43); stereo_frame(28, 44);
    end_run();
    // R8: long and short words
    start_run(3'd1, 1'b0, 1'b0, "R8");
    stereo_frame(40, 51); stereo_frame(16, 52); stereo_frame(16, 53);
    end_run();
    start_run(3'd0, 1'b1, 1'b1, "R8");
    stereo_frame(48, 54); stereo_frame(20, 55);
    end_run();
    // R4: right-justified widths
    for (int c = 2; c <= 5; c++) begin
      start_run(3'(c), 1'(c & 1), 1'(c >> 1 & 1), "R4");
      stereo_frame(32, 60 + c); stereo_frame(32, 70 + c);
      end_run();
    end
    // R5: time-division, exact and long frames
    start_run(3'd6, 1'b1, 1'b0, "R5");
    tdm_frame(256, 81); tdm_frame(256, 82); tdm_frame(288, 83);
    end_run();
    start_run(3'd6, 1'b0, 1'b1, "R5");
    tdm_frame(256, 84); tdm_frame(260, 85);
    end_run();
    // R10: glitch recovery
    start_run(3'd0, 1'b0, 1'b0, "R10");
    ignore = 1'b1;
    for (int i = 0; i < 10; i++) send_bit(pol, filler(i));
    for (int i = 0; i < 3; i++)  send_bit(~pol, filler(i + 1));
    for (int i = 0; i < 5; i++)  send_bit(pol, filler(i + 2));
    for (int i = 0; i < 30; i++) send_bit(~pol, filler(i + 3));
    repeat (8) @(negedge clk);
    ignore = 1'b0;
    stereo_frame(32, 91); stereo_frame(32, 92);
    end_run();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog %s actual=hung expected=done", req);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule